// File: doc/BRIEF.md
# Masked Pseudo-Random Noise Generator

This block produces pseudo-random noise that rides on top of a channel's DC value. A 12-bit linear feedback shift register starts from a fixed seed of 0xAAA. On every accepted step, the current register value is masked down to a run of low bits. The masked value is added to the 12-bit base value with saturation, and the result is registered as the output sample. The register then advances one position.

Noise runs only while the noise-mode select and the channel's trigger enable are both high. A small state machine tracks this with three states:
- `ST_SEEDED`: the mode is off and the register is held at its seed.
- `ST_HALTED`: the mode is on but the trigger is disabled.
- `ST_RUN`: steps are accepted.

The transitions are as follows:
- Any state goes to `ST_SEEDED` whenever the select is low.
- `ST_SEEDED` or `ST_RUN` goes to `ST_HALTED` when the select is high and the trigger is off.
- `ST_SEEDED` or `ST_HALTED` goes to `ST_RUN` when both inputs are high.

The 4-bit mask/amplitude code is captured only while the channel is disabled. It is frozen while the channel runs.

Top module: `dither_noise_gen`

## Requirements
- R1: After reset, `state_o` is 0xAAA and `sum_o` is 0x000.
- R2: An accepted step advances the register by a right shift. The new bit 11 is the XOR of the previous bits 0, 1, 4 and 6, so the sequence from the seed is 0xAAA, 0xD55, 0xEAA, 0xF55.
- R3: The register never holds zero. If it ever does, the next value is 0x800, which injects a 1 at bit 11.
- R4: Mask code n, for n from 0 to 10, keeps bits [n:0] of the register value. Codes 11 to 15 keep all 12 bits.
- R5: The sum is base plus masked value, saturating at 0xFFF.
- R6: On an accepted step, `sum_o` and `state_o` update on that clock edge. `sum_o` is computed from the register value held before the edge. Without an accepted step, `sum_o` holds.
- R7: While `noise_sel_i` is low, steps are ignored and the register returns to 0xAAA at the next clock edge.
- R8: While `trig_en_i` is low and `noise_sel_i` is high, steps are ignored and the register holds.
- R9: `mask_code_i` is captured on every edge where `chan_en_i` is low. While `chan_en_i` is high, the last captured code is used.
- R10: A step is accepted only in `ST_RUN`. That state is entered one edge after both `noise_sel_i` and `trig_en_i` are high, so a step presented in the same cycle that enables the trigger is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| noise_sel_i | input | 1 | Noise mode select; low reseeds the register |
| trig_en_i | input | 1 | Channel trigger enable |
| chan_en_i | input | 1 | Channel enable; high freezes the mask code |
| step_i | input | 1 | Qualified trigger step strobe |
| mask_code_i | input | 4 | Mask/amplitude code |
| base_i | input | 12 | DC holding value |
| sum_o | output | 12 | Saturated sum for the output register |
| state_o | output | 12 | Current shift register state |

## Verification
A table of eight consecutive steps walks the sequence from the seed. Each step pairs a different mask code and base value with a hand-derived sum and next state, so a wrong tap, shift direction or mask width shows up as a miscompare. One row overflows 12 bits, which separates saturation from wrap-around. Directed cases follow:
- disabling the trigger, to show the register holds;
- enabling the trigger and stepping in the same cycle, to show the step is ignored;
- dropping the mode select, to show the register reseeds;
- changing the code while the channel is enabled, to show the frozen mask is the one applied.

// File: rtl/dng_pkg.sv
package dng_pkg;

    localparam int unsigned DNG_W      = 12;
    localparam int unsigned DNG_CODE_W = 4;
    localparam logic [DNG_W-1:0] DNG_SEED = 12'hAAA;
    // taps at bits 0, 1, 4 and 6 of the polynomial x^12+x^6+x^4+x+1
    localparam logic [DNG_W-1:0] DNG_TAPS = 12'h053;

    typedef enum logic [1:0] {
        ST_SEEDED = 2'd0,
        ST_HALTED = 2'd1,
        ST_RUN    = 2'd2
    } run_state_e;

endpackage

// File: rtl/dng_ctrl.sv
module dng_ctrl
    import dng_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic noise_sel_i,
    input  logic trig_en_i,
    input  logic step_i,
    output logic accept_o,
    output logic reseed_o
);

    run_state_e state_q;
    run_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEDED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEDED: begin
                if (noise_sel_i && trig_en_i) begin
                    state_d = ST_RUN;
                end else if (noise_sel_i) begin
                    state_d = ST_HALTED;
                end
            end
            ST_HALTED: begin
                if (!noise_sel_i) begin
                    state_d = ST_SEEDED;
                end else if (trig_en_i) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!noise_sel_i) begin
                    state_d = ST_SEEDED;
                end else if (!trig_en_i) begin
                    state_d = ST_HALTED;
                end
            end
            default: state_d = ST_SEEDED;
        endcase
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        reseed_o = 1'b0;
        unique case (state_q)
            ST_SEEDED: begin
                reseed_o = 1'b1;
            end
            ST_HALTED: begin
                reseed_o = !noise_sel_i;
            end
            ST_RUN: begin
                reseed_o = !noise_sel_i;
                accept_o = step_i && noise_sel_i && trig_en_i;
            end
            default: begin
                reseed_o = 1'b1;
            end
        endcase
        if (!noise_sel_i) begin
            reseed_o = 1'b1;
        end
    end

    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_sel_i && trig_en_i) |=> (state_q == ST_RUN)); // R10

    AST_SEED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !noise_sel_i |=> (state_q == ST_SEEDED) && !accept_o); // R7

endmodule

// File: rtl/dng_lfsr.sv
module dng_lfsr #(
    parameter int unsigned          WIDTH = dng_pkg::DNG_W,
    parameter logic [WIDTH-1:0]     SEED  = dng_pkg::DNG_SEED,
    parameter logic [WIDTH-1:0]     TAPS  = dng_pkg::DNG_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reseed_i,
    input  logic             advance_i,
    output logic [WIDTH-1:0] state_o
);

    localparam logic [WIDTH-1:0] INJECT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] next_val;
    logic             feedback;

    assign feedback = ^(state_q & TAPS);

    always_comb begin
        if (state_q == '0) begin
            next_val = INJECT;
        end else begin
            next_val = {feedback, state_q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (reseed_i) begin
            state_q <= SEED;
        end else if (advance_i) begin
            state_q <= next_val;
        end
    end

    assign state_o = state_q;

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R3

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !reseed_i && state_q != '0)
        |=> state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1])); // R2

    AST_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
        reseed_i |=> state_q == SEED); // R7

endmodule

// File: rtl/dng_mask.sv
module dng_mask #(
    parameter int unsigned WIDTH  = dng_pkg::DNG_W,
    parameter int unsigned CODE_W = dng_pkg::DNG_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [WIDTH-1:0]  mask_o
);

    logic [CODE_W-1:0] code_q;

    // capture only while the channel is disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (!chan_en_i) begin
            code_q <= code_i;
        end
    end

    // bit g kept when g <= code; codes beyond WIDTH-1 keep everything
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign mask_o[g] = (int'(code_q) >= g);
    end

    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en_i |=> $stable(code_q)); // R9

    AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        mask_o[0] && ($countones(mask_o + 1'b1) <= 1)); // R4

endmodule

// File: rtl/dng_satadd.sv
module dng_satadd #(
    parameter int unsigned WIDTH = dng_pkg::DNG_W
) (
    input  logic [WIDTH-1:0] base_i,
    input  logic [WIDTH-1:0] addend_i,
    output logic [WIDTH-1:0] sum_o
);

    logic [WIDTH:0] raw;

    assign raw   = {1'b0, base_i} + {1'b0, addend_i};
    assign sum_o = raw[WIDTH] ? {WIDTH{1'b1}} : raw[WIDTH-1:0];

endmodule

// File: rtl/dither_noise_gen.sv
module dither_noise_gen
    import dng_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  noise_sel_i,
    input  logic                  trig_en_i,
    input  logic                  chan_en_i,
    input  logic                  step_i,
    input  logic [DNG_CODE_W-1:0] mask_code_i,
    input  logic [DNG_W-1:0]      base_i,
    output logic [DNG_W-1:0]      sum_o,
    output logic [DNG_W-1:0]      state_o
);

    logic             accept;
    logic             reseed;
    logic [DNG_W-1:0] lfsr_val;
    logic [DNG_W-1:0] mask;
    logic [DNG_W-1:0] sum_next;
    logic [DNG_W-1:0] sum_q;

    dng_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .noise_sel_i (noise_sel_i),
        .trig_en_i   (trig_en_i),
        .step_i      (step_i),
        .accept_o    (accept),
        .reseed_o    (reseed)
    );

    dng_lfsr #(
        .WIDTH (DNG_W),
        .SEED  (DNG_SEED),
        .TAPS  (DNG_TAPS)
    ) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reseed_i  (reseed),
        .advance_i (accept),
        .state_o   (lfsr_val)
    );

    dng_mask #(
        .WIDTH  (DNG_W),
        .CODE_W (DNG_CODE_W)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en_i (chan_en_i),
        .code_i    (mask_code_i),
        .mask_o    (mask)
    );

    dng_satadd #(
        .WIDTH (DNG_W)
    ) u_add (
        .base_i   (base_i),
        .addend_i (lfsr_val & mask),
        .sum_o    (sum_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (accept) begin
            sum_q <= sum_next;
        end
    end

    assign sum_o   = sum_q;
    assign state_o = lfsr_val;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> sum_o >= $past(base_i)); // R5

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(sum_o)); // R6

    AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_sel_i && !trig_en_i) |=> $stable(state_o)); // R8

endmodule

// File: tb/test_dither_noise_gen.sv
module test_dither_noise_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        noise_sel_i = 1'b0;
    logic        trig_en_i = 1'b0;
    logic        chan_en_i = 1'b0;
    logic        step_i = 1'b0;
    logic [3:0]  mask_code_i = 4'd0;
    logic [11:0] base_i = 12'd0;
    logic [11:0] sum_o;
    logic [11:0] state_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dither_noise_gen i_dither_noise_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .noise_sel_i (noise_sel_i),
        .trig_en_i   (trig_en_i),
        .chan_en_i   (chan_en_i),
        .step_i      (step_i),
        .mask_code_i (mask_code_i),
        .base_i      (base_i),
        .sum_o       (sum_o),
        .state_o     (state_o)
    );

    // {mask code, base, expected sum, expected state after step}
    localparam logic [39:0] VEC [8] = '{
        {4'd15, 12'h000, 12'hAAA, 12'hD55},
        {4'd15, 12'h000, 12'hD55, 12'hEAA},
        {4'd3,  12'h100, 12'h10A, 12'hF55},
        {4'd0,  12'h7FF, 12'h800, 12'hFAA},
        {4'd7,  12'hF80, 12'hFFF, 12'hFD5},
        {4'd11, 12'h001, 12'hFD6, 12'hFEA},
        {4'd10, 12'h010, 12'h7FA, 12'h7F5},
        {4'd5,  12'h000, 12'h035, 12'hBFA}
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
        end
    endtask

    task automatic pulse_step();
        @(negedge clk) step_i = 1'b1;
        @(negedge clk) step_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", state_o, 12'hAAA);
        check("R1 reset sum", sum_o, 12'h000);

        noise_sel_i = 1'b1;
        trig_en_i   = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R2 R4 R5 R6 R3
        for (int i = 0; i < 8; i++) begin
            mask_code_i = VEC[i][39:36];
            base_i      = VEC[i][35:24];
            @(negedge clk);
            pulse_step();
            check("R4/R5/R6 sum", sum_o, VEC[i][23:12]);
            check("R2 next state", state_o, VEC[i][11:0]);
            check("R3 nonzero", 12'(state_o != 12'h000), 12'h001);
        end

        // R8: trigger disabled, step ignored
        trig_en_i = 1'b0;
        @(negedge clk);
        pulse_step();
        check("R8 state held", state_o, 12'hBFA);
        check("R8 sum held", sum_o, 12'h035);

        // R10: enable and step in the same cycle, ignored
        @(negedge clk);
        trig_en_i = 1'b1;
        step_i    = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        check("R10 same-cycle step ignored", state_o, 12'hBFA);
        base_i = 12'h000;
        pulse_step();
        check("R10 step in run sum", sum_o, 12'h03A);
        check("R2 state after run step", state_o, 12'hDFD);

        // R7: mode off reseeds, steps ignored
        noise_sel_i = 1'b0;
        @(negedge clk);
        check("R7 reseed", state_o, 12'hAAA);
        pulse_step();
        check("R7 sum held", sum_o, 12'h03A);
        check("R7 state seeded", state_o, 12'hAAA);

        // R9: code frozen while channel enabled
        mask_code_i = 4'd15;
        noise_sel_i = 1'b1;
        repeat (2) @(negedge clk);
        chan_en_i   = 1'b1;
        mask_code_i = 4'd0;
        @(negedge clk);
        pulse_step();
        check("R9 frozen full mask", sum_o, 12'hAAA);
        chan_en_i = 1'b0;
        @(negedge clk);
        pulse_step();
        check("R9 recaptured code 0", sum_o, 12'h001);

        // R5: saturate at top
        mask_code_i = 4'd15;
        base_i      = 12'hFFF;
        @(negedge clk);
        pulse_step();
        check("R5 saturate", sum_o, 12'hFFF);
        check("R2 state", state_o, 12'hF55);

        finish_run();
    end

endmodule